// File: doc/BRIEF.md
# External Interrupt Pin Flag Controller

This block watches six external interrupt pins. For each pin it latches a status flag when the pin's selected trigger condition occurs. The condition is chosen per channel from four senses: low level, falling edge, rising edge, or either edge. A per-channel enable bit gates each flag onto a registered request output, and a single combined request line is the OR of all six.

A flag can be cleared in three ways:
- Software clears it with a guarded sequence. The status bit must first be read back as 1, and then a 0 must be written to it.
- The core's exception acknowledge for that channel clears it.
- An activation of the transfer engine clears it, provided that activation's keep bit is 0.

An acknowledge of a level-sensed channel clears the flag only once the pin has gone high again. In every case a new trigger in the same cycle as a clear keeps the flag set, so no event is lost.

Software reaches the block through a small byte-wide register port. Reads return data one cycle after the read strobe.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After synchronous reset the enable bits, status flags, sense selections, read data and request outputs are all 0.
- R2: The enable register is at address 0. Its bits 5..0 are read/write, one per channel, and bits 7..6 always read 0. `irq_req[n]` is 1 one cycle after flag n and enable n are both 1. `irq_any` is the OR of `irq_req`.
- R3: Each channel has a 2-bit sense code `{B,A}`: 00 is low level, 01 is falling edge, 10 is rising edge, 11 is both edges. Address 2 holds the codes for channels 3..0 at bits `[2n+1:2n]`. Address 3 holds the codes for channels 5..4 in bits 3..0, and its bits 7..4 read 0.
- R4: Each pin passes through a two-flop synchroniser. A pin change driven before clock edge k shows in the status flag after edge k+2 when it meets the channel's sense. A transition that the sense does not select sets nothing. A flag stays set after the condition ends.
- R5: Writing 1 to a status bit (address 1) has no effect.
- R6: Writing 0 to status bit n clears flag n only if a status read since the last clear of that flag returned bit n as 1.
- R7: An acknowledge for channel n (`ack_valid`, `ack_ch`=n) in any edge sense clears flag n.
- R8: An acknowledge for a level-sensed channel clears the flag only when the synchronised pin is high.
- R9: A transfer activation for channel n clears flag n when `xfer_keep` is 0, and leaves it set when `xfer_keep` is 1.
- R10: When a trigger condition and any clear fall in the same cycle, the flag stays set.
- R11: Status bits 7..6 read 0. Read data is registered and valid the cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 6 | Asynchronous external interrupt pins, idle high |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 enable, 1 status, 2/3 sense |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ack_valid | input | 1 | Exception acknowledge strobe |
| ack_ch | input | 3 | Channel being acknowledged |
| xfer_act | input | 1 | Transfer engine activation strobe |
| xfer_ch | input | 3 | Channel that started the transfer |
| xfer_keep | input | 1 | 1 keeps the flag on activation, 0 clears it |
| irq_req | output | 6 | Per-channel registered request |
| irq_any | output | 1 | OR of all channel requests |

## Verification
The assertions assume that read and write strobes never share a cycle, and that the acknowledge and transfer channel numbers are below six whenever their strobes are high. The bench drives every register access as a single one-cycle strobe and only ever names channels 0 to 5. The pins are held high from reset until the sense codes are programmed, and each pin change gets a settling window longer than the synchroniser latency before the next access.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_ENABLE  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_SENSE_L = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_SENSE_H = 2'd3;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int NCH    = 6,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] lvl,
  output logic [NCH-1:0] lvl_prev
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], pin_in[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign lvl[g]      = chain[STAGES-1];
    assign lvl_prev[g] = prev;
  end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
  import irq_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic       lvl_prev,
  input  logic [1:0] mode,
  input  logic       rd_hit,
  input  logic       wr_zero,
  input  logic       ack_hit,
  input  logic       xfer_hit,
  output logic       flag,
  output logic       marker
);
  logic trig;
  logic clr;

  always_comb begin
    unique case (sense_e'(mode))
      SENSE_LOW:  trig = ~lvl;
      SENSE_FALL: trig = lvl_prev & ~lvl;
      SENSE_RISE: trig = ~lvl_prev & lvl;
      default:    trig = lvl_prev ^ lvl;
    endcase
  end

  assign clr = (wr_zero & marker)
             | (ack_hit & ((sense_e'(mode) != SENSE_LOW) | lvl))
             | xfer_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      marker <= 1'b0;
    end else begin
      if (trig)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (clr)                 marker <= 1'b0;
      else if (rd_hit && flag) marker <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        irq_pin,
  input  logic                  reg_rd,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  ack_valid,
  input  logic [CH_W-1:0]       ack_ch,
  input  logic                  xfer_act,
  input  logic [CH_W-1:0]       xfer_ch,
  input  logic                  xfer_keep,
  output logic [NCH-1:0]        irq_req,
  output logic                  irq_any
);
  localparam int SENSE_W = 2 * NCH;
  localparam int SPAD_W  = 2 * DATA_W;
  localparam logic [SPAD_W-1:0] SENSE_MASK =
    {{(SPAD_W - SENSE_W){1'b0}}, {SENSE_W{1'b1}}};

  logic [NCH-1:0]    en_q;
  logic [SPAD_W-1:0] sense_q;
  logic [NCH-1:0]    lvl, lvl_prev;
  logic [NCH-1:0]    flag_vec, marker_vec;
  logic              st_rd, st_wr;

  assign st_rd = reg_rd && !reg_wr && (reg_addr == ADDR_STATUS);
  assign st_wr = reg_wr && (reg_addr == ADDR_STATUS);

  irq_pin_sync #(.NCH(NCH), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .pin_in(irq_pin), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_cell
    irq_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .lvl(lvl[g]), .lvl_prev(lvl_prev[g]),
      .mode(sense_q[2*g +: 2]),
      .rd_hit(st_rd),
      .wr_zero(st_wr && !reg_wdata[g]),
      .ack_hit(ack_valid && (ack_ch == CH_W'(g))),
      .xfer_hit(xfer_act && !xfer_keep && (xfer_ch == CH_W'(g))),
      .flag(flag_vec[g]), .marker(marker_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      sense_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_ENABLE:  en_q <= reg_wdata[NCH-1:0];
        ADDR_SENSE_L: sense_q[DATA_W-1:0] <= reg_wdata & SENSE_MASK[DATA_W-1:0];
        ADDR_SENSE_H: sense_q[SPAD_W-1:DATA_W] <= reg_wdata & SENSE_MASK[SPAD_W-1:DATA_W];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd && !reg_wr) begin
      case (reg_addr)
        ADDR_ENABLE:  reg_rdata <= {{(DATA_W-NCH){1'b0}}, en_q};
        ADDR_STATUS:  reg_rdata <= {{(DATA_W-NCH){1'b0}}, flag_vec};
        ADDR_SENSE_L: reg_rdata <= sense_q[DATA_W-1:0];
        default:      reg_rdata <= sense_q[SPAD_W-1:DATA_W];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= '0;
      irq_any <= 1'b0;
    end else begin
      irq_req <= flag_vec & en_q;
      irq_any <= |(flag_vec & en_q);
    end
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int NCH    = 6,
  parameter int DATA_W = 8,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              ack_valid,
  input logic [CH_W-1:0]   ack_ch,
  input logic              xfer_act,
  input logic [CH_W-1:0]   xfer_ch,
  input logic              xfer_keep,
  input logic [NCH-1:0]    irq_req,
  input logic              irq_any,
  input logic [NCH-1:0]    en_q,
  input logic [NCH-1:0]    flag,
  input logic [NCH-1:0]    marker,
  input logic [NCH-1:0]    lvl,
  input logic [2*DATA_W-1:0] sense_q
);
  assert_no_rd_wr_collide_R11: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_wr));

  assert_ch_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_valid -> (int'(ack_ch) < NCH)) && (xfer_act -> (int'(xfer_ch) < NCH)));

  assert_unused_bits_zero_R11: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd && !reg_wr && (reg_addr < 2'd2)) |-> (reg_rdata[DATA_W-1:NCH] == '0));

  assert_any_matches_req_R2: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|irq_req));

  assert_marker_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (marker & ~flag) == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assert_req_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
      irq_req[g] |-> $past(en_q[g]));

    assert_clear_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(flag[g]) |->
        $past(reg_wr && reg_addr == 2'd1 && !reg_wdata[g] && marker[g])
        || $past(ack_valid && ack_ch == CH_W'(g))
        || $past(xfer_act && !xfer_keep && xfer_ch == CH_W'(g)));

    assert_level_ack_holds_R8: assert property (@(posedge clk) disable iff (rst)
      $past(ack_valid && ack_ch == CH_W'(g) && sense_q[2*g +: 2] == 2'b00
            && !lvl[g] && flag[g]) |-> flag[g]);
  end
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NCH(NCH), .DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_valid(ack_valid),
  .ack_ch(ack_ch), .xfer_act(xfer_act), .xfer_ch(xfer_ch), .xfer_keep(xfer_keep),
  .irq_req(irq_req), .irq_any(irq_any), .en_q(en_q), .flag(flag_vec),
  .marker(marker_vec), .lvl(lvl), .sense_q(sense_q)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] irq_pin = 6'h3F;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_ch = 3'd0;
  logic       xfer_act = 1'b0;
  logic [2:0] xfer_ch = 3'd0;
  logic       xfer_keep = 1'b0;
  logic [5:0] irq_req;
  logic       irq_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  irq_flag_ctrl uut (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_valid(ack_valid), .ack_ch(ack_ch), .xfer_act(xfer_act),
    .xfer_ch(xfer_ch), .xfer_keep(xfer_keep), .irq_req(irq_req), .irq_any(irq_any)
  );

  always @(posedge clk) rd_seen <= reg_rd & ~rst;

  // monitor: compares registered read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected read data %h, nothing expected", "R11", reg_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (reg_rdata !== e.exp) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", e.tag, reg_rdata, e.exp);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    @(negedge clk);
    sb.push_back(e);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ack(input int ch);
    @(negedge clk);
    ack_valid = 1'b1; ack_ch = 3'(ch);
    @(negedge clk);
    ack_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input int ch, input logic keep);
    @(negedge clk);
    xfer_act = 1'b1; xfer_ch = 3'(ch); xfer_keep = keep;
    @(negedge clk);
    xfer_act = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pin(input int ch, input logic v);
    @(negedge clk);
    irq_pin[ch] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic chk_irq(input logic [5:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq_req !== exp || irq_any !== (|exp)) begin
      errors++;
      $display("FAIL %s: irq_req/any actual %h/%b expected %h/%b",
               tag, irq_req, irq_any, exp, |exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(6'h00, "R1");
    rd(2'd0, 8'h00, "R1 enable");
    rd(2'd1, 8'h00, "R1 status");
    rd(2'd2, 8'h00, "R1 sense");

    // R3 sense codes: ch0 low, ch1 fall, ch2 rise, ch3 both, ch4 fall, ch5 low
    wr(2'd2, 8'hE4);
    wr(2'd3, 8'hF1);
    rd(2'd2, 8'hE4, "R3 sense low");
    rd(2'd3, 8'h01, "R3 sense high");

    // R2 enable with unused bits
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h3F, "R2 enable");

    // R4 falling edge on ch1
    pin(1, 1'b0);
    chk_irq(6'h02, "R4 fall");
    rd(2'd1, 8'h02, "R4 fall status");
    pin(1, 1'b1);
    rd(2'd1, 8'h02, "R4 rise ignored in fall sense");

    // R4 rise on ch2, falling ignored
    pin(2, 1'b0);
    chk_irq(6'h02, "R4 fall ignored in rise sense");
    pin(2, 1'b1);
    chk_irq(6'h06, "R4 rise");

    // R6 only the bit read as 1 clears
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h04, "R6 guard");
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h04, "R5 write one");
    wr(2'd1, 8'hFB);
    rd(2'd1, 8'h00, "R6 clear");

    // R7 both-edge ch3 and acknowledge
    pin(3, 1'b0);
    chk_irq(6'h08, "R4 both fall");
    ack(3);
    rd(2'd1, 8'h00, "R7 ack edge");
    pin(3, 1'b1);
    chk_irq(6'h08, "R4 both rise");
    ack(3);
    chk_irq(6'h00, "R7 ack edge");

    // R8 / R10 level sense ch0
    pin(0, 1'b0);
    chk_irq(6'h01, "R4 level");
    ack(0);
    rd(2'd1, 8'h01, "R8 ack while low");
    wr(2'd1, 8'h3E);
    rd(2'd1, 8'h01, "R10 set wins over write clear");
    pin(0, 1'b1);
    rd(2'd1, 8'h01, "R4 level flag latched");
    ack(0);
    rd(2'd1, 8'h00, "R8 ack while high");

    // R9 transfer activation on ch4
    pin(4, 1'b0);
    xfer(4, 1'b1);
    rd(2'd1, 8'h10, "R9 keep");
    xfer(4, 1'b0);
    rd(2'd1, 8'h00, "R9 clear");
    pin(4, 1'b1);
    rd(2'd1, 8'h00, "R4 rise ignored ch4");

    // R2 enable gating on ch5
    wr(2'd0, 8'h1F);
    rd(2'd0, 8'h1F, "R2 enable write");
    pin(5, 1'b0);
    chk_irq(6'h00, "R2 gated");
    rd(2'd1, 8'h20, "R2 flag set while gated");
    wr(2'd0, 8'h3F);
    repeat (2) @(negedge clk);
    chk_irq(6'h20, "R2 ungated");
    pin(5, 1'b1);
    ack(5);
    chk_irq(6'h00, "R8 ack ch5");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11: actual %0d pending reads expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule